// File: doc/BRIEF.md
# Wakeup Auto-Reload Down-Counter

This block is a periodic wakeup timer that lives in a slow clock domain. A 16-bit counter is loaded from a stored reload value and steps down once per tick. The tick comes from a free-running prescaler, and a 3-bit select field picks the tick rate. When the count reaches zero, a sticky wakeup flag is raised, and the next tick reloads the counter. The flag can clear itself when the count reaches a programmable auto-clear threshold. Software can also clear it with a pulse.

Software controls the timer with a single enable level. The enable is driven from the fast bus clock domain and reaches the timer through a two-flop synchroniser. The reload value, threshold and select field may only change while the timer is stopped. A write-allowed flag reports when this is the case.

Enabling or disabling completes in one of two ways:
- When select bit 2 is low, it completes one slow cycle after the synchronised value arrives.
- When select bit 2 is high, it waits for the next active tick, so the latency is longer and bounded.

The configuration write strobes arrive already in the slow domain.

Top module: `wkup_reload_timer`

## Requirements
- R1: After reset, wr_ok_o is 1, wkup_o is 0, and cnt_o, rld_o, acl_o and sel_o are all 0.
- R2: A write strobe to the reload, threshold or select field is accepted when wr_ok_o is 1 at the slow edge. The new value appears on rld_o, acl_o or sel_o after that edge.
- R3: A write strobe is ignored when wr_ok_o is 0 at the slow edge, and the readback keeps its previous value.
- R4: When sel_o[2] is 0, wr_ok_o takes the inverse of en_async_i on the third slow-clock rising edge after en_async_i changes between edges.
- R5: When sel_o[2] is 1, the change completes on the first slow edge, from the third onward, at which the tick is active. The latency is therefore between 3 and 2+P edges, where P is the tick period.
- R6: The prescaler counts up by one on every slow edge from reset. The tick is active in a cycle when the low S bits of the prescaler are all ones, where S = sel[1:0] + (sel[2] ? HI_SHIFT : 0) and HI_SHIFT defaults to 3. P is 2^S.
- R7: When an enable completes, the count is loaded with the reload value. While running, each tick decrements the count, and a tick at count 0 reloads it.
- R8: A running tick that makes the count 0 sets wkup_o, and wkup_o stays set.
- R9: For a nonzero threshold, a running tick that makes the count equal to the threshold clears wkup_o. A threshold of 0 never clears it.
- R10: A flag_clr_i pulse clears wkup_o at the next edge. A set in the same edge takes priority over the clear.
- R11: While stopped, cnt_o holds its value, and ticks do not change wkup_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow_i | input | 1 | Slow timer clock |
| rst_slow_ni | input | 1 | Asynchronous active-low reset |
| en_async_i | input | 1 | Enable level from the bus clock domain |
| rld_we_i | input | 1 | Reload value write strobe |
| rld_wdata_i | input | CNT_W | Reload value write data |
| acl_we_i | input | 1 | Auto-clear threshold write strobe |
| acl_wdata_i | input | CNT_W | Auto-clear threshold write data |
| sel_we_i | input | 1 | Tick select write strobe |
| sel_wdata_i | input | 3 | Tick select write data |
| flag_clr_i | input | 1 | Wakeup flag clear pulse |
| wr_ok_o | output | 1 | Configuration may be written (timer stopped) |
| wkup_o | output | 1 | Sticky wakeup flag |
| cnt_o | output | CNT_W | Current count |
| rld_o | output | CNT_W | Reload value readback |
| acl_o | output | CNT_W | Auto-clear threshold readback |
| sel_o | output | 3 | Tick select readback |

## Verification
The bench sweeps all eight select codes against reload values 0, 1 and 3 and several thresholds. It compares every slow cycle with an arithmetic model, so a prescaler mask that is off by one bit shows up as a wrong count on a specific cycle. Enable and disable latency is measured in slow edges:
- A design that skipped a synchroniser stage would report 2 instead of 3.
- A design that ignored the tick alignment would finish early when select bit 2 is set.

In each run, the bench attempts configuration writes while the timer is running, which exposes a missing write gate. A reload of 0 makes the counter wake on every tick. A threshold equal to the reload catches an auto-clear that compares against the wrong value. The bench also checks the latched reload on the enable edge, so a design that loaded the value written in that same cycle would be caught.

// File: rtl/wkt_pkg.sv
`timescale 1ns/1ps
package wkt_pkg;
    localparam int unsigned SEL_W  = 3;
    localparam int unsigned SEL_HI = 2;

    typedef struct packed {
        logic run;
        logic wr_ok;
    } hs_state_t;
endpackage

// File: rtl/wkt_sync.sv
`timescale 1ns/1ps
module wkt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] ff_d, ff_q;

    always_comb begin
        ff_d = {ff_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= ff_d;
    end

    assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/wkt_prescaler.sv
`timescale 1ns/1ps
module wkt_prescaler
    import wkt_pkg::*;
#(
    parameter int unsigned HI_SHIFT = 3,
    parameter int unsigned PRE_W    = 3 + HI_SHIFT
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int unsigned SH_W = $clog2(PRE_W + 1);

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [SH_W-1:0]  shift;
    logic [PRE_W-1:0] low_mask;

    always_comb begin
        pre_d    = pre_q + PRE_W'(1);
        shift    = SH_W'(sel_i[1:0]) + (sel_i[SEL_HI] ? SH_W'(HI_SHIFT) : '0);
        low_mask = ~({PRE_W{1'b1}} << shift);
        tick_o   = &(pre_q | ~low_mask);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pre_q <= '0;
        else         pre_q <= pre_d;
    end
endmodule

// File: rtl/wkt_handshake.sv
`timescale 1ns/1ps
module wkt_handshake
    import wkt_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_s_i,
    input  logic sel_hi_i,
    input  logic tick_i,
    output logic run_o,
    output logic wr_ok_o,
    output logic chg_o,
    output logic load_o
);
    hs_state_t st_d, st_q;
    logic      chg;

    always_comb begin
        st_d = st_q;
        chg  = (en_s_i != st_q.run) && (!sel_hi_i || tick_i);
        if (chg) begin
            st_d.run   = en_s_i;
            st_d.wr_ok = !en_s_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{run: 1'b0, wr_ok: 1'b1};
        else         st_q <= st_d;
    end

    assign run_o   = st_q.run;
    assign wr_ok_o = st_q.wr_ok;
    assign chg_o   = chg;
    assign load_o  = chg && en_s_i;
endmodule

// File: rtl/wkt_cfg_regs.sv
`timescale 1ns/1ps
module wkt_cfg_regs
    import wkt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_ok_i,
    input  logic             rld_we_i,
    input  logic [CNT_W-1:0] rld_wdata_i,
    input  logic             acl_we_i,
    input  logic [CNT_W-1:0] acl_wdata_i,
    input  logic             sel_we_i,
    input  logic [SEL_W-1:0] sel_wdata_i,
    output logic [CNT_W-1:0] rld_o,
    output logic [CNT_W-1:0] acl_o,
    output logic [SEL_W-1:0] sel_o
);
    typedef struct packed {
        logic [CNT_W-1:0] rld;
        logic [CNT_W-1:0] acl;
        logic [SEL_W-1:0] sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_ok_i) begin
            if (rld_we_i) cfg_d.rld = rld_wdata_i;
            if (acl_we_i) cfg_d.acl = acl_wdata_i;
            if (sel_we_i) cfg_d.sel = sel_wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign rld_o = cfg_q.rld;
    assign acl_o = cfg_q.acl;
    assign sel_o = cfg_q.sel;
endmodule

// File: rtl/wkt_down_counter.sv
`timescale 1ns/1ps
module wkt_down_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             cnt_en_i,
    input  logic [CNT_W-1:0] rld_i,
    input  logic [CNT_W-1:0] acl_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } ctr_t;

    ctr_t             st_d, st_q;
    logic [CNT_W-1:0] nxt;
    logic             hit_zero;
    logic             hit_acl;

    always_comb begin
        st_d     = st_q;
        hit_zero = 1'b0;
        hit_acl  = 1'b0;
        nxt      = (st_q.cnt == '0) ? rld_i : st_q.cnt - CNT_W'(1);
        if (load_i) begin
            st_d.cnt = rld_i;
        end else if (cnt_en_i) begin
            st_d.cnt = nxt;
            hit_zero = (nxt == '0);
            hit_acl  = (acl_i != '0) && (nxt == acl_i);
        end
        if (hit_zero)                  st_d.flag = 1'b1;
        else if (hit_acl || flag_clr_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign flag_o = st_q.flag;
endmodule

// File: rtl/wkup_reload_timer.sv
`timescale 1ns/1ps
module wkup_reload_timer
    import wkt_pkg::*;
#(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned HI_SHIFT = 3
) (
    input  logic             clk_slow_i,
    input  logic             rst_slow_ni,
    input  logic             en_async_i,
    input  logic             rld_we_i,
    input  logic [CNT_W-1:0] rld_wdata_i,
    input  logic             acl_we_i,
    input  logic [CNT_W-1:0] acl_wdata_i,
    input  logic             sel_we_i,
    input  logic [2:0]       sel_wdata_i,
    input  logic             flag_clr_i,
    output logic             wr_ok_o,
    output logic             wkup_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] rld_o,
    output logic [CNT_W-1:0] acl_o,
    output logic [2:0]       sel_o
);
    localparam int unsigned PRE_W = 3 + HI_SHIFT;

    logic en_s;
    logic tick;
    logic run;
    logic chg;
    logic load;
    logic cnt_en;

    wkt_sync #(.STAGES(2)) u_sync (
        .clk_i  (clk_slow_i),
        .rst_ni (rst_slow_ni),
        .d_i    (en_async_i),
        .q_o    (en_s)
    );

    wkt_prescaler #(.HI_SHIFT(HI_SHIFT), .PRE_W(PRE_W)) u_pre (
        .clk_i  (clk_slow_i),
        .rst_ni (rst_slow_ni),
        .sel_i  (sel_o),
        .tick_o (tick)
    );

    wkt_handshake u_hs (
        .clk_i    (clk_slow_i),
        .rst_ni   (rst_slow_ni),
        .en_s_i   (en_s),
        .sel_hi_i (sel_o[SEL_HI]),
        .tick_i   (tick),
        .run_o    (run),
        .wr_ok_o  (wr_ok_o),
        .chg_o    (chg),
        .load_o   (load)
    );

    wkt_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
        .clk_i       (clk_slow_i),
        .rst_ni      (rst_slow_ni),
        .wr_ok_i     (wr_ok_o),
        .rld_we_i    (rld_we_i),
        .rld_wdata_i (rld_wdata_i),
        .acl_we_i    (acl_we_i),
        .acl_wdata_i (acl_wdata_i),
        .sel_we_i    (sel_we_i),
        .sel_wdata_i (sel_wdata_i),
        .rld_o       (rld_o),
        .acl_o       (acl_o),
        .sel_o       (sel_o)
    );

    assign cnt_en = run && tick && !chg;

    wkt_down_counter #(.CNT_W(CNT_W)) u_ctr (
        .clk_i      (clk_slow_i),
        .rst_ni     (rst_slow_ni),
        .load_i     (load),
        .cnt_en_i   (cnt_en),
        .rld_i      (rld_o),
        .acl_i      (acl_o),
        .flag_clr_i (flag_clr_i),
        .cnt_o      (cnt_o),
        .flag_o     (wkup_o)
    );
endmodule

// File: rtl/wkup_reload_timer_chk.sv
`timescale 1ns/1ps
module wkup_reload_timer_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk_slow_i,
    input logic             rst_slow_ni,
    input logic             flag_clr_i,
    input logic             wr_ok_o,
    input logic             wkup_o,
    input logic [CNT_W-1:0] cnt_o,
    input logic [CNT_W-1:0] rld_o,
    input logic [CNT_W-1:0] acl_o,
    input logic [2:0]       sel_o
);
    AST_CFG_LOCKED: assert property (@(posedge clk_slow_i) disable iff (!rst_slow_ni)
        !wr_ok_o |=> ($stable(rld_o) && $stable(acl_o) && $stable(sel_o))); // R3

    AST_LOAD_ON_START: assert property (@(posedge clk_slow_i) disable iff (!rst_slow_ni)
        $fell(wr_ok_o) |-> (cnt_o == $past(rld_o))); // R7

    AST_RUN_STEP: assert property (@(posedge clk_slow_i) disable iff (!rst_slow_ni)
        (!wr_ok_o && $past(!wr_ok_o) && (cnt_o != $past(cnt_o))) |->
        ((cnt_o == $past(cnt_o) - CNT_W'(1)) || (($past(cnt_o) == '0) && (cnt_o == rld_o)))); // R7

    AST_STOPPED_HOLD: assert property (@(posedge clk_slow_i) disable iff (!rst_slow_ni)
        (wr_ok_o && $past(wr_ok_o)) |-> $stable(cnt_o)); // R11

    AST_WAKE_AT_ZERO: assert property (@(posedge clk_slow_i) disable iff (!rst_slow_ni)
        $rose(wkup_o) |-> (cnt_o == '0)); // R8

    AST_AUTO_CLEAR: assert property (@(posedge clk_slow_i) disable iff (!rst_slow_ni)
        ($fell(wkup_o) && !$past(flag_clr_i)) |-> ((acl_o != '0) && (cnt_o == acl_o))); // R9
endmodule

bind wkup_reload_timer wkup_reload_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk_slow_i  (clk_slow_i),
    .rst_slow_ni (rst_slow_ni),
    .flag_clr_i  (flag_clr_i),
    .wr_ok_o     (wr_ok_o),
    .wkup_o      (wkup_o),
    .cnt_o       (cnt_o),
    .rld_o       (rld_o),
    .acl_o       (acl_o),
    .sel_o       (sel_o)
);

// File: tb/wkup_reload_timer_tb_top.sv
`timescale 1ns/1ps
module wkup_reload_timer_tb_top;
    localparam int CNT_W = 16;
    localparam int HI    = 3;

    logic bus_clk = 1'b0;
    logic slow_clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_i = 1'b0;
    logic rld_we = 1'b0, acl_we = 1'b0, sel_we = 1'b0, clr = 1'b0;
    logic [CNT_W-1:0] rld_wd = '0, acl_wd = '0;
    logic [2:0] sel_wd = '0;
    logic wr_ok, wkup;
    logic [CNT_W-1:0] cnt, rld_rb, acl_rb;
    logic [2:0] sel_rb;

    int n_chk = 0;
    int n_fail = 0;
    int edge_cnt = 0;
    int bus_cyc = 0;
    bit cyc_check = 1'b0;
    bit done = 1'b0;

    always #10 bus_clk = ~bus_clk;
    initial begin
        #85;
        forever begin
            slow_clk = ~slow_clk;
            #80;
        end
    end

    wkup_reload_timer #(.CNT_W(CNT_W), .HI_SHIFT(HI)) dut_i (
        .clk_slow_i(slow_clk), .rst_slow_ni(rst_n), .en_async_i(en_i),
        .rld_we_i(rld_we), .rld_wdata_i(rld_wd), .acl_we_i(acl_we), .acl_wdata_i(acl_wd),
        .sel_we_i(sel_we), .sel_wdata_i(sel_wd), .flag_clr_i(clr),
        .wr_ok_o(wr_ok), .wkup_o(wkup), .cnt_o(cnt), .rld_o(rld_rb), .acl_o(acl_rb), .sel_o(sel_rb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model of the slow domain, built from the requirements
    logic m_s1, m_s2, m_run, m_ok, m_flag;
    logic [5:0] m_pre;
    logic [CNT_W-1:0] m_cnt, m_rld, m_acl, m_nx;
    logic [2:0] m_sel;
    int m_sh;
    logic [5:0] m_lm;
    logic m_tk, m_chg;

    always @(posedge slow_clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_run <= 0; m_ok <= 1; m_flag <= 0;
            m_pre <= 0; m_cnt <= 0; m_rld <= 0; m_acl <= 0; m_sel <= 0;
        end else begin
            edge_cnt++;
            m_sh  = int'(m_sel[1:0]) + (m_sel[2] ? HI : 0);
            m_lm  = 6'((1 << m_sh) - 1);
            m_tk  = ((m_pre & m_lm) == m_lm);
            m_chg = (m_s2 != m_run) && (!m_sel[2] || m_tk);
            m_s1 <= en_i;
            m_s2 <= m_s1;
            m_pre <= m_pre + 6'd1;
            if (m_ok) begin
                if (rld_we) m_rld <= rld_wd;
                if (acl_we) m_acl <= acl_wd;
                if (sel_we) m_sel <= sel_wd;
            end
            if (m_chg) begin
                m_run <= m_s2;
                m_ok  <= !m_s2;
                if (m_s2) m_cnt <= m_rld;
                if (clr) m_flag <= 0;
            end else if (m_run && m_tk) begin
                m_nx = (m_cnt == 0) ? m_rld : m_cnt - 16'd1;
                m_cnt <= m_nx;
                if (m_nx == 0) m_flag <= 1;
                else if ((m_acl != 0 && m_nx == m_acl) || clr) m_flag <= 0;
            end else if (clr) begin
                m_flag <= 0;
            end
        end
    end

    always @(negedge slow_clk) begin
        if (cyc_check && rst_n) begin
            chk(wr_ok == m_ok, "R4 R5 wr_ok_o", int'(wr_ok), int'(m_ok));
            chk(cnt == m_cnt, "R6 R7 R11 cnt_o", int'(cnt), int'(m_cnt));
            chk(wkup == m_flag, "R8 R9 R10 wkup_o", int'(wkup), int'(m_flag));
        end
    end

    always @(posedge bus_clk) begin
        bus_cyc++;
        if (bus_cyc > 190000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual %0d expected %0d", bus_cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wr_cfg(input int r, input int a, input int s, input bit accept);
        logic [CNT_W-1:0] or_, oa;
        logic [2:0] os;
        @(negedge slow_clk);
        or_ = rld_rb; oa = acl_rb; os = sel_rb;
        rld_we = 1; acl_we = 1; sel_we = 1;
        rld_wd = CNT_W'(r); acl_wd = CNT_W'(a); sel_wd = 3'(s);
        @(negedge slow_clk);
        rld_we = 0; acl_we = 0; sel_we = 0;
        if (accept) begin
            chk(rld_rb == CNT_W'(r), "R2 rld_o", int'(rld_rb), r);
            chk(acl_rb == CNT_W'(a), "R2 acl_o", int'(acl_rb), a);
            chk(sel_rb == 3'(s), "R2 sel_o", int'(sel_rb), s);
        end else begin
            chk(rld_rb == or_, "R3 rld_o", int'(rld_rb), int'(or_));
            chk(acl_rb == oa, "R3 acl_o", int'(acl_rb), int'(oa));
            chk(sel_rb == os, "R3 sel_o", int'(sel_rb), int'(os));
        end
    endtask

    task automatic set_en(input bit v);
        int e0, lat, per, guard;
        @(negedge slow_clk);
        @(negedge bus_clk);
        en_i = v;
        e0 = edge_cnt;
        guard = 0;
        do begin
            @(negedge slow_clk);
            guard++;
        end while (wr_ok != !v && guard < 300);
        lat = edge_cnt - e0;
        per = 1 << (int'(sel_rb[1:0]) + (sel_rb[2] ? HI : 0));
        if (!sel_rb[2]) chk(lat == 3, "R4 latency", lat, 3);
        else chk(lat >= 3 && lat <= 2 + per, "R5 latency", lat, 2 + per);
    endtask

    initial begin
        repeat (3) @(negedge slow_clk);
        rst_n = 1'b1;
        @(negedge slow_clk);
        chk(wr_ok == 1'b1, "R1 wr_ok_o", int'(wr_ok), 1);
        chk(wkup == 1'b0, "R1 wkup_o", int'(wkup), 0);
        chk(cnt == '0, "R1 cnt_o", int'(cnt), 0);
        chk(rld_rb == '0 && acl_rb == '0 && sel_rb == '0, "R1 config", int'(rld_rb), 0);
        cyc_check = 1'b1;

        for (int s = 0; s < 8; s++) begin
            for (int ri = 0; ri < 3; ri++) begin
                for (int ai = 0; ai < 3; ai++) begin
                    int r, a, per;
                    r = (ri == 2) ? 3 : ri;
                    a = (ai == 0) ? 0 : ((ai == 1) ? 1 : r);
                    per = 1 << ((s & 3) + ((s & 4) != 0 ? HI : 0));
                    wr_cfg(r, a, s, 1'b1);
                    set_en(1'b1);
                    chk(cnt == CNT_W'(r), "R7 load", int'(cnt), r);
                    repeat (per * (r + 1)) @(negedge slow_clk);
                    wr_cfg(r + 7, a + 5, s ^ 1, 1'b0);
                    repeat (per * (r + 1) + 3) @(negedge slow_clk);
                    set_en(1'b0);
                    repeat (per + 2) @(negedge slow_clk);
                    chk(cnt == m_cnt, "R11 held", int'(cnt), int'(m_cnt));
                    if (wkup) begin
                        @(negedge slow_clk); clr = 1'b1;
                        @(negedge slow_clk); clr = 1'b0;
                        chk(wkup == 1'b0, "R10 clear", int'(wkup), 0);
                    end
                end
            end
        end

        wr_cfg(0, 0, 0, 1'b1);
        set_en(1'b1);
        repeat (2) @(negedge slow_clk);
        clr = 1'b1;
        @(negedge slow_clk);
        clr = 1'b0;
        chk(wkup == 1'b1, "R10 set wins", int'(wkup), 1);
        set_en(1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule